// File: doc/BRIEF.md
# Pin change interrupt detector

This block watches a bank of synchronized general-purpose input levels, split into ports of equal width, and pulls an active-low interrupt line when an enabled input pin has changed level since its port was last read. Every port keeps a snapshot of its pin levels. A pin is compared against that snapshot, and any difference raises a sticky pending flag. A rising change and a falling change both count. A pin that moves away and then comes back still leaves its flag set.

The register bank supplies two kinds of control. The first is a per-pin interrupt-disable vector and a per-pin direction vector. The second is a per-port clear pulse, which the register bank issues when software reads that port's input-state register. A clear reloads the port's snapshot from the live pins and drops that port's pending flags. Software therefore reads both ports once after configuration, which removes any flags that setup changes left behind.

Top module: `pcirq_top`

## Requirements
- R1: While rst_ni is low, every bit of pend_o is 0 and irq_no is 1.
- R2: Pin i belongs to port i/8, at bit i%8 within the port. If pin i has dir_in_i[i]=1 (input) and irq_dis_i[i]=0, no clear is pulsed for its port, and its level differs from the port snapshot at a rising clock edge, then pend_o[i] is 1 after that edge. This holds for both 0-to-1 and 1-to-0 changes.
- R3: A set pend_o bit stays 1 until its port receives a clear pulse, even if the pin returns to its snapshot level.
- R4: A pin with irq_dis_i=1 (masked) or dir_in_i=0 (output) never sets its pend_o bit.
- R5: Setting irq_dis_i for a pending pin removes that pin's effect on irq_no in the same cycle, without waiting for a clock edge. The pend_o bit itself stays set. Clearing the mask again brings the effect back.
- R6: clr_i[p]=1 at a rising edge loads the snapshot of port p with the current pin levels and zeroes every pend_o bit of port p. The other port is not affected.
- R7: irq_no is 0 exactly when at least one pend_o bit is 1 and that pin's irq_dis_i bit is 0. The line therefore stays low until every port holding such a bit has been cleared.
- R8: If a pin changes in the same cycle as its port's clear, the snapshot takes the new level and no flag is set. A later return to the old level is then detected as a change.
- R9: Each snapshot resets to all zeros. Input pins that are high after reset therefore pend, and one clear of both ports removes those setup flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_lvl_i | input | NUM_PORTS*PORT_W | Synchronized pin levels; pin i at bit i |
| dir_in_i | input | NUM_PORTS*PORT_W | 1 = pin configured as input |
| irq_dis_i | input | NUM_PORTS*PORT_W | 1 = pin interrupt masked, 0 = enabled |
| clr_i | input | NUM_PORTS | Per-port clear pulse from an input-state read |
| pend_o | output | NUM_PORTS*PORT_W | Sticky per-pin pending flags |
| irq_no | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its defaults: two ports of eight pins. At that size the boundary between pin 7 and pin 8 is visible, and a clear on one port can be checked to leave the other port's flags untouched. Directed steps cover a change in each direction, a pin toggling away and back, masking and unmasking a pending pin within one cycle, and a clear that lands on the same edge as a pin change. A long stretch with random pins, masks, directions and clears is then checked against a behavioural per-pin model on every clock.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
  localparam int unsigned PORTS_DEF = 2;
  localparam int unsigned WIDTH_DEF = 8;

  // pins able to raise a flag: inputs that are not masked
  function automatic logic watch_bit(logic dir_in, logic dis);
    return dir_in & ~dis;
  endfunction
endpackage

// File: rtl/pcirq_port.sv
module pcirq_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] watch_i,
  input  logic         clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] snap_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] diff;

  assign diff = lvl_i ^ snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      pend_q <= '0;
    end else if (clr_i) begin
      // clear wins over a coincident change; snapshot absorbs it
      snap_q <= lvl_i;
      pend_q <= '0;
    end else begin
      pend_q <= pend_q | (diff & watch_i);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pcirq_merge.sv
module pcirq_merge #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] dis_i,
  output logic         irq_no
);
  assign irq_no = ~|(pend_i & ~dis_i);
endmodule

// File: rtl/pcirq_top.sv
module pcirq_top
  import pcirq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = PORTS_DEF,
  parameter int unsigned PORT_W    = WIDTH_DEF
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_lvl_i,
  input  logic [NUM_PORTS*PORT_W-1:0]   dir_in_i,
  input  logic [NUM_PORTS*PORT_W-1:0]   irq_dis_i,
  input  logic [NUM_PORTS-1:0]          clr_i,
  output logic [NUM_PORTS*PORT_W-1:0]   pend_o,
  output logic                          irq_no
);
  localparam int unsigned NPINS = NUM_PORTS * PORT_W;

  logic [NPINS-1:0] watch;

  for (genvar i = 0; i < NPINS; i++) begin : g_watch
    assign watch[i] = watch_bit(dir_in_i[i], irq_dis_i[i]);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pcirq_port #(.W(PORT_W)) port_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (pin_lvl_i[p*PORT_W +: PORT_W]),
      .watch_i(watch[p*PORT_W +: PORT_W]),
      .clr_i  (clr_i[p]),
      .pend_o (pend_o[p*PORT_W +: PORT_W])
    );
  end

  pcirq_merge #(.N(NPINS)) merge_i (
    .pend_i(pend_o),
    .dis_i (irq_dis_i),
    .irq_no(irq_no)
  );
endmodule

// File: rtl/pcirq_chk.sv
module pcirq_chk #(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned PORT_W    = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_PORTS*PORT_W-1:0] pin_lvl_i,
  input logic [NUM_PORTS*PORT_W-1:0] dir_in_i,
  input logic [NUM_PORTS*PORT_W-1:0] irq_dis_i,
  input logic [NUM_PORTS-1:0]        clr_i,
  input logic [NUM_PORTS*PORT_W-1:0] pend_o,
  input logic                        irq_no
);
  localparam int unsigned NPINS = NUM_PORTS * PORT_W;

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pend_o == '0) && irq_no);

  // R7
  no_pend_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(pend_o) == 0) |-> irq_no);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int unsigned P = i / PORT_W;

    // R2
    change_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(clr_i[P]) && !clr_i[P] && dir_in_i[i] && !irq_dis_i[i] &&
       (pin_lvl_i[i] != $past(pin_lvl_i[i]))) |=> pend_o[i]);

    // R3
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[i] && !clr_i[P]) |=> pend_o[i]);

    // R4
    quiet_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_o[i] && (irq_dis_i[i] || !dir_in_i[i])) |=> !pend_o[i]);

    // R6
    clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[P] |=> !pend_o[i]);

    // R5
    live_pend_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[i] && !irq_dis_i[i]) |-> !irq_no);
  end
endmodule

bind pcirq_top pcirq_chk #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pin_lvl_i(pin_lvl_i),
  .dir_in_i (dir_in_i),
  .irq_dis_i(irq_dis_i),
  .clr_i    (clr_i),
  .pend_o   (pend_o),
  .irq_no   (irq_no)
);

// File: tb/pcirq_top_tb_top.sv
`timescale 1ns/1ps
module pcirq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pins = 16'hA5C3;
  logic [15:0] dir  = 16'hFFFF;
  logic [15:0] dis  = 16'h0000;
  logic [1:0]  clr  = 2'b00;
  logic [15:0] pend;
  logic        irq_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pcirq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_lvl_i(pins), .dir_in_i(dir),
    .irq_dis_i(dis), .clr_i(clr), .pend_o(pend), .irq_no(irq_n)
  );

  // behavioural reference
  logic [15:0] m_snap, m_pend;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_snap = '0;
      m_pend = '0;
    end else begin
      for (int i = 0; i < 16; i++) begin
        if (clr[i/8]) begin
          m_snap[i] = pins[i];
          m_pend[i] = 1'b0;
        end else if (dir[i] && !dis[i] && pins[i] != m_snap[i]) begin
          m_pend[i] = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic exp_irq_n(input logic [15:0] pv, input logic [15:0] mv);
    for (int i = 0; i < 16; i++) if (pv[i] && !mv[i]) return 1'b0;
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 R3 R6 pend vs model", {16'h0, pend}, {16'h0, m_pend});
      chk("R7 irq vs model", {31'h0, irq_n}, {31'h0, exp_irq_n(m_pend, dis)});
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired got=running exp=done");
    finish_run();
  end

  initial begin
    tick(); tick();
    chk("R1 reset pend", {16'h0, pend}, 32'h0);
    chk("R1 reset irq", {31'h0, irq_n}, 32'h1);
    rst_n = 1'b1;
    tick();
    chk("R9 setup flags", {16'h0, pend}, 32'hA5C3);
    chk("R9 setup irq", {31'h0, irq_n}, 32'h0);
    clr = 2'b11; tick(); clr = 2'b00;
    chk("R9 cleared", {16'h0, pend}, 32'h0);
    chk("R9 cleared irq", {31'h0, irq_n}, 32'h1);

    pins[3] = 1'b1; tick();
    chk("R2 rising", {16'h0, pend}, 32'h0008);
    pins[8] = 1'b0; tick();
    chk("R2 falling", {16'h0, pend}, 32'h0108);
    pins[3] = 1'b0; tick();
    chk("R3 returned pin stays", {16'h0, pend}, 32'h0108);
    clr = 2'b01; tick(); clr = 2'b00;
    chk("R6 port0 only", {16'h0, pend}, 32'h0100);
    chk("R7 still low", {31'h0, irq_n}, 32'h0);
    clr = 2'b10; tick(); clr = 2'b00;
    chk("R7 all cleared", {31'h0, irq_n}, 32'h1);

    dis[5] = 1'b1; pins[5] = ~pins[5];
    dir[12] = 1'b0; pins[12] = ~pins[12];
    tick(); tick();
    chk("R4 masked/output", {16'h0, pend}, 32'h0);
    chk("R4 irq idle", {31'h0, irq_n}, 32'h1);
    dis[5] = 1'b0; dir[12] = 1'b1; clr = 2'b11; tick(); clr = 2'b00;
    tick();
    chk("R6 resnap", {16'h0, pend}, 32'h0);

    pins[14] = ~pins[14]; tick();
    chk("R5 pending", {16'h0, pend}, 32'h4000);
    dis[14] = 1'b1; #1;
    chk("R5 mask immediate", {31'h0, irq_n}, 32'h1);
    chk("R5 flag kept", {16'h0, pend}, 32'h4000);
    dis[14] = 1'b0; #1;
    chk("R5 unmask immediate", {31'h0, irq_n}, 32'h0);
    clr = 2'b10; tick(); clr = 2'b00;

    clr = 2'b01; pins[0] = ~pins[0]; tick(); clr = 2'b00;
    chk("R8 coincident", {16'h0, pend}, 32'h0);
    pins[0] = ~pins[0]; tick();
    chk("R8 return detected", {16'h0, pend}, 32'h0001);
    clr = 2'b01; tick(); clr = 2'b00; tick();
    chk("R6 final", {16'h0, pend}, 32'h0);

    for (int k = 0; k < 400; k++) begin
      pins = pins ^ ($urandom() & $urandom() & 16'hFFFF);
      if ((k % 7) == 0) dis = $urandom();
      if ((k % 11) == 0) dir = $urandom() | $urandom();
      clr = (($urandom() % 4) == 0) ? 2'($urandom()) : 2'b00;
      tick();
    end
    clr = 2'b00; tick();
    finish_run();
  end
endmodule